// File: doc/BRIEF.md
# Link Training Status Evaluator

This block interprets the six status bytes a display sink reports during link training, together with the number of lanes in use (1, 2 or 4). It decides whether clock recovery has completed on every active lane, and whether channel equalization, symbol lock and inter-lane alignment have all completed. A training controller polls these two verdicts to decide whether to keep adjusting the drive or move to the next phase.

The block also reads the drive adjustment the sink asks for on each lane. It takes the strongest swing and the strongest pre-emphasis requested over the active lanes and clamps each to its limit: pre-emphasis has a limit that drops as swing rises. It then packs the result into one training byte with max-reached flags, which it presents identically for all four lanes. The status fetch and the analog transmitter sit outside the block. An optional output register, selected by a parameter, adds one cycle of latency.

Top module: `lt_status_eval`

## Requirements
- R1: The status of lane n is the 4-bit nibble at bit offset 4*(n%2) of status byte n/2, where byte k occupies `link_status_i[8k+7:8k]`. Within the nibble, bit 0 is clock recovered, bit 1 is equalized and bit 2 is symbol locked.
- R2: `cr_done_o` is 1 exactly when nibble bit 0 is set on every active lane.
- R3: `eq_done_o` is 1 exactly when bit 0 of status byte 2 (alignment done) is set and every active lane has nibble bits 2:0 all set.
- R4: Adjust byte 4 serves lanes 0/1 and byte 5 serves lanes 2/3. The even lane takes swing from bits 1:0 and pre-emphasis from bits 3:2; the odd lane takes swing from bits 5:4 and pre-emphasis from bits 7:6. The chosen swing is the largest swing requested over the active lanes, and the chosen pre-emphasis is the largest pre-emphasis requested over them.
- R5: A chosen swing of 3 is kept at 3 and the swing-max flag is set; a smaller swing clears the flag.
- R6: The pre-emphasis ceiling is 2 for swing 0 or 1, 1 for swing 2 and 0 for swing 3. A chosen pre-emphasis at or above the ceiling is replaced by the ceiling and the pre-emphasis-max flag is set; otherwise the flag is clear.
- R7: The training byte carries swing in bits 1:0, the swing-max flag in bit 2, pre-emphasis in bits 4:3 and the pre-emphasis-max flag in bit 5. Bits 7:6 are 0.
- R8: The same training byte appears in all four byte slots of `lane_train_o` (lane k in bits 8k+7:8k), whatever the lane count.
- R9: `lane_cnt_i` values 1 and 2 select one and two active lanes (lanes 0 and 0-1). Every other value selects four lanes. Status and requests of inactive lanes have no effect on any output.
- R10: Status byte 3 and bits 7:1 of status byte 2 have no effect on any output.
- R11: With `REG_OUT`=1 the outputs are registered: a new input shows at the outputs after the next rising clock edge, and while `rst_ni` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_cnt_i | input | 3 | Active lane count (1, 2, otherwise 4) |
| link_status_i | input | 48 | Six sink status bytes, byte k at bits 8k+7:8k |
| cr_done_o | output | 1 | Clock recovery complete on all active lanes |
| eq_done_o | output | 1 | Equalization, symbol lock and alignment complete |
| lane_train_o | output | 32 | Merged training byte, repeated for lanes 0..3 |

## Verification
The status sweep goes over every lane count from 0 to 7. It assigns each lane one of four nibbles: clock only, clock plus equalized, all three bits, and everything but clock. It sets the alignment bit both ways and fills byte 3 and the upper alignment bits with changing junk. This shows which lanes the verdicts depend on and that the junk has no effect. The adjust sweep covers all 65536 request-byte pairs at four lanes, and a strided subset at one, two and the unsupported count 3. Expected bytes come from a separate arithmetic model. Large requests on inactive lanes and every swing/pre-emphasis pair reach the clamp and flag corners. A separate check shows the reset value and the one-cycle register latency.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int unsigned LANES      = 4;
  localparam int unsigned STAT_BYTES = 6;
  localparam int unsigned STAT_W     = 8 * STAT_BYTES;
  localparam int unsigned LVL_W      = 2;
  localparam int unsigned ALIGN_BYTE = 2;
  localparam int unsigned ADJ_BYTE   = 4;
  localparam int unsigned CNT_W      = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       pre_max;
    lvl_t       pre;
    logic       swing_max;
    lvl_t       swing;
  } train_t;

  function automatic lvl_t pre_ceiling(lvl_t sw);
    case (sw)
      2'd0, 2'd1: return 2'd2;
      2'd2:       return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lt_lane_mask.sv
module lt_lane_mask
  import lt_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    case (cnt_i)
      3'd1:    mask_o = 4'b0001;
      3'd2:    mask_o = 4'b0011;
      default: mask_o = 4'b1111; // 4 and unsupported counts
    endcase
  end
endmodule

// File: rtl/lt_lane_check.sv
module lt_lane_check
  import lt_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  input  logic [LANES-1:0]  mask_i,
  output logic              cr_ok_o,
  output logic              eq_ok_o
);
  logic [LANES-1:0] cr_pass;
  logic [LANES-1:0] eq_pass;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned OFS = 8 * (l / 2) + 4 * (l % 2);
    logic [3:0] nib;
    assign nib        = status_i[OFS +: 4];
    assign cr_pass[l] = nib[0] | ~mask_i[l];
    assign eq_pass[l] = (&nib[2:0]) | ~mask_i[l];
  end

  assign cr_ok_o = &cr_pass;
  assign eq_ok_o = status_i[8*ALIGN_BYTE] & (&eq_pass);
endmodule

// File: rtl/lt_drive_merge.sv
module lt_drive_merge
  import lt_pkg::*;
(
  input  logic [15:0]      adj_i,
  input  logic [LANES-1:0] mask_i,
  output train_t           train_o
);
  lvl_t sw_req [LANES];
  lvl_t pe_req [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_req
    localparam int unsigned OFS = 8 * (l / 2) + 4 * (l % 2);
    // inactive lanes contribute level 0, neutral for max
    assign sw_req[l] = mask_i[l] ? adj_i[OFS +: 2]     : '0;
    assign pe_req[l] = mask_i[l] ? adj_i[OFS + 2 +: 2] : '0;
  end

  lvl_t sw_top, pe_top, ceil;

  always_comb begin
    sw_top = '0;
    pe_top = '0;
    for (int l = 0; l < LANES; l++) begin
      if (sw_req[l] > sw_top) sw_top = sw_req[l];
      if (pe_req[l] > pe_top) pe_top = pe_req[l];
    end
  end

  assign ceil = pre_ceiling(sw_top);

  always_comb begin
    train_o           = '0;
    train_o.swing     = sw_top;
    train_o.swing_max = (sw_top == 2'd3);
    train_o.pre_max   = (pe_top >= ceil);
    train_o.pre       = (pe_top >= ceil) ? ceil : pe_top;
  end
endmodule

// File: rtl/lt_status_eval.sv
module lt_status_eval
  import lt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     lane_cnt_i,
  input  logic [STAT_W-1:0]    link_status_i,
  output logic                 cr_done_o,
  output logic                 eq_done_o,
  output logic [8*LANES-1:0]   lane_train_o
);
  logic [LANES-1:0]   mask;
  logic               cr_c, eq_c;
  train_t             train_c;
  logic [8*LANES-1:0] bcast_c;

  lt_lane_mask u_mask (
    .cnt_i  (lane_cnt_i),
    .mask_o (mask)
  );

  lt_lane_check u_check (
    .status_i (link_status_i),
    .mask_i   (mask),
    .cr_ok_o  (cr_c),
    .eq_ok_o  (eq_c)
  );

  lt_drive_merge u_merge (
    .adj_i   (link_status_i[8*ADJ_BYTE +: 16]),
    .mask_i  (mask),
    .train_o (train_c)
  );

  assign bcast_c = {LANES{train_c}};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cr_done_o    <= 1'b0;
        eq_done_o    <= 1'b0;
        lane_train_o <= '0;
      end else begin
        cr_done_o    <= cr_c;
        eq_done_o    <= eq_c;
        lane_train_o <= bcast_c;
      end
    end
  end else begin : g_comb
    assign cr_done_o    = cr_c;
    assign eq_done_o    = eq_c;
    assign lane_train_o = bcast_c;
  end

  train_t t0;
  assign t0 = train_t'(lane_train_o[7:0]);

  a_r3_eq_needs_cr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_done_o |-> cr_done_o);

  a_r8_lanes_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_train_o[8*LANES-1:8] == {(LANES-1){lane_train_o[7:0]}});

  a_r5_swing_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0.swing_max == (t0.swing == 2'd3));

  a_r6_pre_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0.pre <= pre_ceiling(t0.swing));

  a_r6_pre_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0.pre_max |-> (t0.pre == pre_ceiling(t0.swing)));

  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0.rsvd == 2'b00);
endmodule

// File: tb/tb_lt_status_eval.sv
module tb_lt_status_eval;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  lane_cnt_i = 3'd4;
  logic [47:0] link_status_i = '0;
  logic        cr_done_o, eq_done_o;
  logic [31:0] lane_train_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lt_status_eval #(.REG_OUT(1'b1)) dut (
    .clk_i, .rst_ni, .lane_cnt_i, .link_status_i,
    .cr_done_o, .eq_done_o, .lane_train_o
  );

  function automatic int active_lanes(logic [2:0] c);
    if (c == 3'd1) return 1;
    if (c == 3'd2) return 2;
    return 4;
  endfunction

  function automatic bit exp_cr(logic [47:0] s, int n);
    for (int l = 0; l < n; l++)
      if (((s >> (8*(l/2) + 4*(l%2))) & 48'h1) == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit exp_eq(logic [47:0] s, int n);
    if (s[16] == 1'b0) return 1'b0;
    for (int l = 0; l < n; l++)
      if (((s >> (8*(l/2) + 4*(l%2))) & 48'h7) != 48'h7) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_train(logic [15:0] adj, int n);
    int sw, pe, ceil, sf, pf;
    sw = 0; pe = 0;
    for (int l = 0; l < n; l++) begin
      int v_sw, v_pe;
      v_sw = (adj >> (8*(l/2) + 4*(l%2))) & 3;
      v_pe = (adj >> (8*(l/2) + 4*(l%2) + 2)) & 3;
      if (v_sw > sw) sw = v_sw;
      if (v_pe > pe) pe = v_pe;
    end
    sf = (sw >= 3) ? 1 : 0;
    if (sw > 3) sw = 3;
    ceil = (sw < 2) ? 2 : (sw == 2 ? 1 : 0);
    pf = (pe >= ceil) ? 1 : 0;
    if (pe > ceil) pe = ceil;
    return 8'(pf*32 + pe*8 + sf*4 + sw);
  endfunction

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cnt=%0d status=%h)",
               tag, act, exp, lane_cnt_i, link_status_i);
    end
  endtask

  // drive at negedge, registered result sampled at the following negedge
  task automatic apply(logic [2:0] c, logic [47:0] s);
    lane_cnt_i    = c;
    link_status_i = s;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    int n;
    logic [47:0] s;
    logic [7:0]  tb;
    logic [3:0]  nib_set [4];
    nib_set[0] = 4'h1; nib_set[1] = 4'h3; nib_set[2] = 4'h7; nib_set[3] = 4'hE;

    // R11: reset state
    repeat (3) @(negedge clk_i);
    check1("R11 reset cr", 32'(cr_done_o), 32'd0);
    check1("R11 reset eq", 32'(eq_done_o), 32'd0);
    check1("R11 reset train", lane_train_o, 32'd0);
    rst_ni = 1'b1;

    // R11: one-cycle latency
    apply(3'd4, 48'h0);
    check1("R11 settle cr", 32'(cr_done_o), 32'd0);
    lane_cnt_i    = 3'd4;
    link_status_i = 48'h0000_0001_7777;
    #1;
    check1("R11 before edge", 32'(cr_done_o), 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    check1("R11 after edge cr", 32'(cr_done_o), 32'd1);
    check1("R11 after edge eq", 32'(eq_done_o), 32'd1);

    // R1 R2 R3 R9 R10: status sweep with junk in byte 3 and align[7:1]
    for (int c = 0; c < 8; c++) begin
      n = active_lanes(3'(c));
      for (int p = 0; p < 256; p++) begin
        for (int al = 0; al < 2; al++) begin
          s = '0;
          for (int l = 0; l < 4; l++)
            s[4*l +: 4] = nib_set[(p >> (2*l)) & 3];
          s[23:16] = {7'(p * 5 + c), 1'(al)};
          s[31:24] = 8'(p ^ 8'h5A);
          s[47:32] = 16'(p * 257);
          apply(3'(c), s);
          check1("R2 R1 R9 R10 cr", 32'(cr_done_o), 32'(exp_cr(s, n)));
          check1("R3 R1 R9 R10 eq", 32'(eq_done_o), 32'(exp_eq(s, n)));
        end
      end
    end

    // R4 R5 R6 R7 R8 R9: adjust sweep
    for (int k = 0; k < 4; k++) begin
      logic [2:0] c;
      int step;
      c = (k == 0) ? 3'd4 : (k == 1) ? 3'd1 : (k == 2) ? 3'd2 : 3'd3;
      step = (k == 0) ? 1 : 13;
      n = active_lanes(c);
      for (int v = 0; v < 65536; v += step) begin
        s = {16'(v), 32'h0};
        apply(c, s);
        tb = exp_train(16'(v), n);
        check1("R4 R5 R6 R7 R8 R9 train", lane_train_o, {4{tb}});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule